// File: doc/BRIEF.md
# Flash Write Completion Status Poller

This block sits on the host side of a parallel NOR flash. A separate sequencer writes the program or erase command. The poller then waits for the device to finish the internal operation. At start it latches four things: the operation kind (program or erase), the status method, the bit-7 value of the word being programmed, and a timeout in clock cycles. While latched, it watches the command write strobes go by and stays silent until the last strobe of the sequence has passed. A program sequence has four strobes and an erase sequence has six.

It then reads the target location repeatedly over a request/acknowledge read port. The status method decides how each returned word is judged. With the complement method, bit 7 reads inverted (program) or 0 (erase) while the device is busy. With the toggle method, bit 6 alternates on successive reads while the device is busy. A read that looks finished is never trusted alone. Two further reads must agree before completion is accepted, and a disagreeing read sends the block back to polling. Once completion is confirmed, the block waits a settling interval before one last full-word read. It then presents that word with a done pulse. If no completion is seen in time, it raises an error pulse instead.

Top module: `flash_done_poller`

## Requirements
- R1: A start pulse while idle latches the operation, method, expected bit and timeout, and busy_o is high from the next cycle. busy_o drops in the same cycle that done_o or err_o pulses.
- R2: No read is requested before the final command strobe after start: the 4th strobe for a program (op_erase_i=0) or the 6th for an erase (op_erase_i=1). The first request is high in the cycle after that strobe is sampled.
- R3: rd_req_o stays high until rd_ack_i is sampled high. It is low for at least one cycle after each acknowledge, and it is never high while busy_o is low.
- R4: Complement method (mode_toggle_i=0) on a program: a read looks finished when its bit 7 equals exp_msb_i.
- R5: Complement method on an erase: a read looks finished when its bit 7 is 1.
- R6: Toggle method (mode_toggle_i=1): a read looks finished when its bit 6 equals bit 6 of the read just before it. The first read of a poll never looks finished.
- R7: A read that looks finished must be followed by two more reads that also look finished. If either of them does not, polling resumes, and that failing read becomes the previous read for the toggle method.
- R8: After the second confirming read, at least SETTLE_CYC cycles pass with no request. Then one final read is made, and its word appears on result_o while done_o pulses.
- R9: When a polling read that does not look finished is acknowledged after at least timeout_i cycles of polling, err_o pulses and no further read is made.
- R10: start_i is ignored while busy_o is high.
- R11: done_o and err_o are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a wait (taken only when idle) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = toggle method (bit 6), 0 = complement method (bit 7) |
| exp_msb_i | input | 1 | Bit 7 of the word being programmed |
| timeout_i | input | TW | Polling limit in clock cycles |
| cmd_strobe_i | input | 1 | One pulse per command write strobe |
| rd_req_o | output | 1 | Read request to the flash port |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i valid |
| rd_data_i | input | DW | Word read from the target location |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Timeout pulse |
| result_o | output | DW | Word from the final read |

## Verification
Several properties are checked on every cycle by assertions. The handshake must hold the request until it is acknowledged and leave a gap afterwards. No request may appear while idle or before the last command strobe. The two ending pulses must be exclusive and one cycle long, and busy must drop together with them. The way each status method judges a word can only be shown by the bench scenarios, which compare the total read count and final word against arithmetic predictions. The same applies to the two-read confirmation with a planted false completion, to the settling gap before the final read, and to the timeout window.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_POLL,
    ST_CONF,
    ST_SETTLE,
    ST_FINAL
  } fdp_state_t;

  localparam int PROG_STROBES  = 4;
  localparam int ERASE_STROBES = 6;
  localparam int BIT_CPL       = 7;
  localparam int BIT_TGL       = 6;
endpackage

// File: rtl/fdp_counter.sv
module fdp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = '0;
    else if (en && cnt_q != '1)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fdp_strobe_gate.sv
module fdp_strobe_gate
  import fdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  input  logic erase,
  output logic last_o
);
  localparam int CW = $clog2(ERASE_STROBES + 1);

  logic [CW-1:0] cnt_q, cnt_d, need;

  assign need   = erase ? CW'(ERASE_STROBES - 1) : CW'(PROG_STROBES - 1);
  assign last_o = strobe && (cnt_q == need);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (strobe) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fdp_status_eval.sv
module fdp_status_eval (
  input  logic toggle,
  input  logic erase,
  input  logic exp_msb,
  input  logic word_b7,
  input  logic word_b6,
  input  logic prev_b6,
  input  logic prev_vld,
  output logic ok_o
);
  always_comb begin
    if (toggle)     ok_o = prev_vld && (word_b6 == prev_b6);
    else if (erase) ok_o = word_b7;
    else            ok_o = (word_b7 == exp_msb);
  end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fdp_pkg::*;
#(
  parameter int DW         = 16,
  parameter int TW         = 16,
  parameter int SETTLE_CYC = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_erase_i,
  input  logic          mode_toggle_i,
  input  logic          exp_msb_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          cmd_strobe_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] result_o
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  fdp_state_t    state_q, state_d;
  logic          erase_q, erase_d, toggle_q, toggle_d, expb_q, expb_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          prev6_q, prev6_d, pvld_q, pvld_d, conf_q, conf_d;
  logic          req_q, req_d, done_q, done_d, err_q, err_d;
  logic [DW-1:0] res_q, res_d;

  logic          fire, ok, gate_last, expired, settle_end;
  logic [TW-1:0] poll_cnt;
  logic [SW-1:0] settle_cnt;

  assign fire = req_q && rd_ack_i;

  fdp_strobe_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_q == ST_IDLE),
    .strobe (cmd_strobe_i && (state_q == ST_ARM)),
    .erase  (erase_q),
    .last_o (gate_last)
  );

  fdp_counter #(.W(TW)) u_poll_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!(state_q inside {ST_POLL, ST_CONF})),
    .en    (1'b1),
    .cnt_o (poll_cnt)
  );

  fdp_counter #(.W(SW)) u_settle_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != ST_SETTLE),
    .en    (1'b1),
    .cnt_o (settle_cnt)
  );

  fdp_status_eval u_eval (
    .toggle   (toggle_q),
    .erase    (erase_q),
    .exp_msb  (expb_q),
    .word_b7  (rd_data_i[BIT_CPL]),
    .word_b6  (rd_data_i[BIT_TGL]),
    .prev_b6  (prev6_q),
    .prev_vld (pvld_q),
    .ok_o     (ok)
  );

  assign expired    = (poll_cnt >= tmo_q);
  assign settle_end = (settle_cnt == SW'(SETTLE_CYC - 1));

  always_comb begin
    state_d  = state_q;
    erase_d  = erase_q;
    toggle_d = toggle_q;
    expb_d   = expb_q;
    tmo_d    = tmo_q;
    prev6_d  = prev6_q;
    pvld_d   = pvld_q;
    conf_d   = conf_q;
    res_d    = res_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          erase_d  = op_erase_i;
          toggle_d = mode_toggle_i;
          expb_d   = exp_msb_i;
          tmo_d    = timeout_i;
          state_d  = ST_ARM;
        end
      end
      ST_ARM: begin
        if (gate_last) begin
          pvld_d  = 1'b0;
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (fire) begin
          prev6_d = rd_data_i[BIT_TGL];
          pvld_d  = 1'b1;
          if (ok) begin
            conf_d  = 1'b0;
            state_d = ST_CONF;
          end else if (expired) begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_CONF: begin
        if (fire) begin
          prev6_d = rd_data_i[BIT_TGL];
          pvld_d  = 1'b1;
          if (!ok)        state_d = ST_POLL;
          else if (conf_q) state_d = ST_SETTLE;
          else            conf_d  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (settle_end) state_d = ST_FINAL;
      end
      ST_FINAL: begin
        if (fire) begin
          res_d   = rd_data_i;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    req_d = (state_d inside {ST_POLL, ST_CONF, ST_FINAL}) && !fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      erase_q  <= 1'b0;
      toggle_q <= 1'b0;
      expb_q   <= 1'b0;
      tmo_q    <= '0;
      prev6_q  <= 1'b0;
      pvld_q   <= 1'b0;
      conf_q   <= 1'b0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      res_q    <= '0;
    end else begin
      state_q  <= state_d;
      erase_q  <= erase_d;
      toggle_q <= toggle_d;
      expb_q   <= expb_d;
      tmo_q    <= tmo_d;
      prev6_q  <= prev6_d;
      pvld_q   <= pvld_d;
      conf_q   <= conf_d;
      req_q    <= req_d;
      done_q   <= done_d;
      err_q    <= err_d;
      res_q    <= res_d;
    end
  end

  assign rd_req_o = req_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign result_o = res_q;
endmodule

// File: rtl/flash_done_poller_chk.sv
module flash_done_poller_chk
  import fdp_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic op_erase_i,
  input logic cmd_strobe_i,
  input logic rd_req_o,
  input logic rd_ack_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  logic [2:0] strb_q, need_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
      need_q <= 3'(PROG_STROBES);
      seen_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      strb_q <= '0;
      need_q <= op_erase_i ? 3'(ERASE_STROBES) : 3'(PROG_STROBES);
      seen_q <= 1'b0;
    end else begin
      if (cmd_strobe_i && busy_o && !seen_q && strb_q != 3'd7) strb_q <= strb_q + 3'd1;
      if (rd_req_o) seen_q <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o);                                    // R3
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && rd_ack_i |=> !rd_req_o);                                    // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o);                                                 // R3
  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !seen_q |-> strb_q >= need_q);                              // R2
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);                                         // R1
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o);                                         // R1
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));                                                    // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                                    // R11
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);                                                      // R11
endmodule

bind flash_done_poller flash_done_poller_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .op_erase_i   (op_erase_i),
  .cmd_strobe_i (cmd_strobe_i),
  .rd_req_o     (rd_req_o),
  .rd_ack_i     (rd_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
  localparam int DW = 16;
  localparam int TW = 12;
  localparam int ST = 10;

  logic          clk, rst_n;
  logic          start_i, op_erase_i, mode_toggle_i, exp_msb_i, cmd_strobe_i;
  logic [TW-1:0] timeout_i;
  logic          rd_req_o, rd_ack_i, busy_o, done_o, err_o;
  logic [DW-1:0] rd_data_i, result_o;

  flash_done_poller #(.DW(DW), .TW(TW), .SETTLE_CYC(ST)) u_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .mode_toggle_i(mode_toggle_i), .exp_msb_i(exp_msb_i), .timeout_i(timeout_i),
    .cmd_strobe_i(cmd_strobe_i), .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .result_o(result_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model state
  logic [DW-1:0] m_exp;
  bit m_erase;
  int m_k, m_glitch, m_lat;
  int nreads, t_ack, t_first, last_gap, wcnt;
  bit in_req;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] mdl_word(input int n);
    logic [DW-1:0] w;
    if (n >= m_k) return m_exp;
    w = ~m_exp;
    w[7] = m_erase ? 1'b0 : ~m_exp[7];
    w[6] = 1'(n % 2);
    if (n == m_glitch) w[7] = m_erase ? 1'b1 : m_exp[7];
    return w;
  endfunction

  function automatic int exp_reads(input bit tog, input logic [DW-1:0] ex, input int k);
    int a;
    if (!tog)     a = k;
    else if (k == 1) a = 2;
    else a = (ex[6] == 1'((k - 1) % 2)) ? k : k + 1;
    return a + 3;
  endfunction

  // read responder
  initial begin
    rd_ack_i = 1'b0; rd_data_i = '0; nreads = 0; in_req = 0; wcnt = 0;
    t_ack = 0; t_first = 0; last_gap = 0;
    forever begin
      @(negedge clk);
      if (rd_ack_i) rd_ack_i = 1'b0;
      else if (rd_req_o) begin
        if (!in_req) begin
          in_req = 1; nreads++; last_gap = cyc - t_ack; wcnt = 0;
          if (nreads == 1) t_first = cyc;
        end
        if (wcnt >= m_lat) begin
          rd_ack_i = 1'b1; rd_data_i = mdl_word(nreads); t_ack = cyc; in_req = 0;
        end else wcnt++;
      end
    end
  end

  task automatic run_case(input bit tog, input bit er, input logic [DW-1:0] ex,
                          input int k, input int g, input int tmo, input bit want_err);
    int need, lim, t_err;
    string tag;
    tag = want_err ? "R9" : (g != 0 ? "R7" : (tog ? "R6" : (er ? "R5" : "R4")));
    m_exp = ex; m_erase = er; m_k = k; m_glitch = g; m_lat = k % 3;
    need = er ? 6 : 4;
    @(negedge clk);
    nreads = 0;
    start_i = 1; op_erase_i = er; mode_toggle_i = tog; exp_msb_i = ex[7];
    timeout_i = TW'(tmo);
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    for (int i = 0; i < need; i++) begin
      @(negedge clk);
      chk(rd_req_o == 1'b0, "R2 no read before last strobe", rd_req_o, 0);
      cmd_strobe_i = 1;
      if (i == 1) begin start_i = 1; op_erase_i = !er; end
      @(negedge clk);
      cmd_strobe_i = 0; start_i = 0;
    end
    chk(rd_req_o == 1'b1, "R2 R10 read right after last strobe", rd_req_o, 1);
    lim = 0;
    while (!done_o && !err_o && lim < 20000) begin @(negedge clk); lim++; end
    t_err = cyc;
    if (want_err) begin
      chk(err_o == 1'b1 && done_o == 1'b0, "R9 error raised", err_o, 1);
      chk((t_err - t_first) >= tmo && (t_err - t_first) <= tmo + 10,
          "R9 error window", t_err - t_first, tmo);
      chk(busy_o == 1'b0, "R1 busy low at error", busy_o, 0);
      @(negedge clk);
      chk(err_o == 1'b0, "R11 error single pulse", err_o, 0);
      repeat (3) @(negedge clk);
      chk(rd_req_o == 1'b0, "R3 R9 no read after error", rd_req_o, 0);
    end else begin
      chk(done_o == 1'b1 && err_o == 1'b0, {tag, " done raised"}, done_o, 1);
      chk(nreads == exp_reads(tog, ex, k), {tag, " read count"}, nreads, exp_reads(tog, ex, k));
      chk(result_o == ex, "R8 final word", result_o, ex);
      chk(last_gap >= ST, "R8 settle gap", last_gap, ST);
      chk(busy_o == 1'b0, "R1 busy low at done", busy_o, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R11 done single pulse", done_o, 0);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] pats [4];
    pats[0] = 16'h1234; pats[1] = 16'hABCD; pats[2] = 16'h5A40; pats[3] = 16'h2580;
    rst_n = 0; start_i = 0; op_erase_i = 0; mode_toggle_i = 0; exp_msb_i = 0;
    timeout_i = '0; cmd_strobe_i = 0;
    m_exp = '0; m_erase = 0; m_k = 1; m_glitch = 0; m_lat = 0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && rd_req_o == 0, "R1 R3 reset idle", {busy_o, rd_req_o}, 0);
    chk(done_o == 0 && err_o == 0, "R11 reset pulses low", {done_o, err_o}, 0);
    rst_n = 1;
    // program, both methods, sweep completion point and data
    for (int tog = 0; tog < 2; tog++)
      for (int p = 0; p < 4; p++)
        for (int k = 1; k <= 6; k++)
          run_case(1'(tog), 1'b0, pats[p], k, 0, 4000, 1'b0);
    // erase, both methods
    for (int tog = 0; tog < 2; tog++)
      for (int k = 1; k <= 6; k++)
        run_case(1'(tog), 1'b1, 16'hFFFF, k, 0, 4000, 1'b0);
    // planted false completions must be rejected by the confirming reads
    run_case(1'b0, 1'b0, 16'h1234, 6, 2, 4000, 1'b0);
    run_case(1'b0, 1'b0, 16'hABCD, 5, 1, 4000, 1'b0);
    run_case(1'b0, 1'b1, 16'hFFFF, 7, 3, 4000, 1'b0);
    // device never finishes
    run_case(1'b0, 1'b0, 16'hABCD, 1000000, 0, 60, 1'b1);
    run_case(1'b1, 1'b1, 16'hFFFF, 1000000, 0, 45, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule